// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block decides who owns a shared external bus. The owner is normally an on-chip processor core. An external master takes the bus through a handshake on three wires. The master asks with an active-low request. The arbiter answers with an active-low grant, and the new owner confirms with an active-low acknowledge. Two on-chip DMA engines can also take the bus: a multi-channel serial DMA and an independent DMA. While either engine owns the bus, the arbiter drives the acknowledge line itself. If the serial DMA needs the bus while an external master holds it, a bus-clear output asks that master to give the bus back. A pending interrupt can be set to raise the bus-clear output as well.

When the core is switched off by configuration, the wires change roles. The arbiter then pulls the request line low on behalf of the DMA engines, and it reads the grant line as an input. Open-drain pads appear in the design as active-low drive enables. The acknowledge pad is split into an input value (`ack_n_in`) and a drive enable (`ack_drv_n`). The external request, acknowledge and grant inputs each pass through a two-flop synchronizer. The DMA requests, the interrupt flag and the cycle-complete strobe come from the same clock domain as the arbiter.

Top module: `bus_arb_ctrl`

## Requirements
- R1: While `rst` is high, `gnt_n` equals `ext_req_n` in the same cycle. After reset is released, every registered output is inactive: `gnt_n`=1, `ack_drv_n`=1, `bclr_drv_n`=1, `req_drv_n`=1, `gnt_oe`=1, `core_bus_en`=1, `dma_own`=0, `sdma_ch`=0.
- R2: A low `ext_req_n` drives `gnt_n` low three clock edges after the change. The core keeps the bus (`core_bus_en`=1) until the edge that samples `cyc_done`. If the request is withdrawn before it is acknowledged, the grant drops and the core keeps the bus.
- R3: The grant is withdrawn (`gnt_n`=1) on the third edge after the external master asserts `ack_n_in` low following the cycle-complete strobe. The external master then owns the bus.
- R4: No grant is given while `ack_n_in` is held low by a previous master. The grant appears three edges after `ack_n_in` is released, if the request is still pending.
- R5: Ownership goes back to the core only when `ack_n_in` is high and no external request is pending. If `ack_n_in` is released while the request is still low, the grant is reissued immediately and the core does not get the bus back.
- R6: While an external master owns the bus, `bclr_drv_n` goes low one edge after any `sdma_req` bit rises, and returns high one edge after the request clears.
- R7: A pending interrupt (`irq_pend`) drives `bclr_drv_n` low during external ownership only when `irq_clr_en`=1.
- R8: With the core enabled, an internal DMA request takes the bus only on an edge where `cyc_done` is high. The acknowledge is then driven (`ack_drv_n`=0) and `dma_own` shows the owner: 1 for the serial DMA, 2 for the independent DMA.
- R9: A serial request steals the bus from the independent DMA on the next `cyc_done`, with no cycle where `ack_drv_n` is high. `sdma_ch` then gives the lowest-numbered requesting channel.
- R10: With `core_off`=1, the grant is not driven (`gnt_oe`=0, `gnt_n`=1), `ext_req_n` is ignored, and `req_drv_n` is low while a DMA request is pending. The DMA takes the bus on the third edge after `ext_gnt_n_in` goes low, and `req_drv_n` is then released.
- R11: A DMA owner gives the bus up only on a `cyc_done` edge with no DMA request pending. `ack_drv_n` then returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_off | input | 1 | Configuration: the internal core is disabled |
| irq_clr_en | input | 1 | Configuration: a pending interrupt also raises bus clear |
| ext_req_n | input | 1 | External bus request pad, active low |
| ext_gnt_n_in | input | 1 | Grant pad read as an input while the core is off, active low |
| ack_n_in | input | 1 | Grant-acknowledge pad input value, active low |
| sdma_req | input | N_SDMA | Serial DMA channel requests |
| idma_req | input | 1 | Independent DMA request |
| irq_pend | input | 1 | The core has a pending interrupt |
| cyc_done | input | 1 | Current bus cycle completes this clock |
| gnt_n | output | 1 | Bus grant, active low |
| gnt_oe | output | 1 | Grant pad output enable |
| ack_drv_n | output | 1 | Acknowledge pad drive enable, low pulls the line low |
| bclr_drv_n | output | 1 | Bus-clear open-drain drive, active low |
| req_drv_n | output | 1 | Request pad open-drain drive while the core is off |
| core_bus_en | output | 1 | The core owns the bus and may start cycles |
| dma_own | output | 2 | Internal owner: 0 none, 1 serial DMA, 2 independent DMA |
| sdma_ch | output | CH_W | Serial channel that owns the bus |

## Verification
The external handshake is tried three ways, and each shows a different rule. In a clean request, grant and acknowledge, the grant drop can be timed against the synchronizer delay. When the acknowledge is held over from a previous master, the bench can confirm that no grant is issued. When the acknowledge is released with the request still pending, the re-grant is distinguished from a return to the core. DMA patterns compare an independent request arriving with and without a cycle-complete strobe, a serial request stealing the bus from the independent DMA, and the return of the bus, so that stealing and releasing can be told apart. The core-off pattern checks that the wires change direction and that the external request is ignored.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  typedef enum logic [1:0] {
    ST_CORE  = 2'd0,
    ST_GPEND = 2'd1,
    ST_EXT   = 2'd2,
    ST_DMA   = 2'd3
  } arb_st_t;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_SDMA = 2'd1,
    OWN_IDMA = 2'd2
  } dma_own_t;

endpackage

// File: rtl/bus_arb_sync.sv
module bus_arb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bus_arb_pick.sv
module bus_arb_pick
  import bus_arb_pkg::*;
#(
  parameter int N_SDMA = 3,
  parameter int CH_W   = 2
) (
  input  logic [N_SDMA-1:0] sdma_req,
  input  logic              idma_req,
  output dma_own_t          pick,
  output logic [CH_W-1:0]   pick_ch,
  output logic              sdma_any
);

  // Lowest channel index wins among the serial requests.
  always_comb begin
    pick_ch = '0;
    for (int i = N_SDMA - 1; i >= 0; i--) begin
      if (sdma_req[i]) pick_ch = CH_W'(i);
    end
  end

  assign sdma_any = |sdma_req;

  always_comb begin
    if (sdma_any)      pick = OWN_SDMA;
    else if (idma_req) pick = OWN_IDMA;
    else               pick = OWN_NONE;
  end

endmodule

// File: rtl/bus_arb_fsm.sv
module bus_arb_fsm
  import bus_arb_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            core_off,
  input  logic            irq_clr_en,
  input  logic            irq_pend,
  input  logic            cyc_done,
  input  logic            ext_req_s,
  input  logic            ack_s,
  input  logic            ext_gnt_s,
  input  dma_own_t        pick,
  input  logic [CH_W-1:0] pick_ch,
  input  logic            sdma_any,
  output logic            gnt_q,
  output logic            oe_q,
  output logic            ack_q,
  output logic            bclr_q,
  output logic            req_q,
  output logic            core_q,
  output dma_own_t        own_q,
  output logic [CH_W-1:0] ch_q
);

  arb_st_t         st, nst;
  dma_own_t        nown;
  logic [CH_W-1:0] nch;
  logic            rel_q, nrel;

  always_comb begin
    nst  = st;
    nown = own_q;
    nch  = ch_q;
    nrel = rel_q;
    case (st)
      ST_CORE: begin
        nrel = 1'b0;
        if (core_off) begin
          if (pick != OWN_NONE && ext_gnt_s && !ack_s) begin
            nst  = ST_DMA;
            nown = pick;
            nch  = pick_ch;
          end
        end else if (cyc_done && pick != OWN_NONE) begin
          nst  = ST_DMA;
          nown = pick;
          nch  = pick_ch;
        end else if (ext_req_s && !ack_s) begin
          nst = ST_GPEND;
        end
      end
      ST_GPEND: begin
        if (core_off || !ext_req_s) begin
          nst  = ST_CORE;
          nrel = 1'b0;
        end else if (rel_q && ack_s) begin
          nst = ST_EXT;
        end else if (cyc_done) begin
          nrel = 1'b1;
        end
      end
      ST_EXT: begin
        if (!ack_s) begin
          if (ext_req_s && !core_off) begin
            nst  = ST_GPEND;
            nrel = 1'b1;
          end else begin
            nst  = ST_CORE;
            nrel = 1'b0;
          end
        end
      end
      ST_DMA: begin
        if (cyc_done) begin
          nown = pick;
          nch  = pick_ch;
          if (pick == OWN_NONE) nst = ST_CORE;
        end
      end
      default: nst = ST_CORE;
    endcase
    if (nst != ST_DMA)     nown = OWN_NONE;
    if (nown != OWN_SDMA)  nch  = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_CORE;
      rel_q  <= 1'b0;
      own_q  <= OWN_NONE;
      ch_q   <= '0;
      gnt_q  <= 1'b0;
      oe_q   <= 1'b1;
      ack_q  <= 1'b0;
      bclr_q <= 1'b0;
      req_q  <= 1'b0;
      core_q <= 1'b1;
    end else begin
      st     <= nst;
      rel_q  <= nrel;
      own_q  <= nown;
      ch_q   <= nch;
      gnt_q  <= (nst == ST_GPEND) && !core_off;
      oe_q   <= !core_off;
      ack_q  <= (nst == ST_DMA);
      bclr_q <= (nst == ST_EXT) && (sdma_any || (irq_clr_en && irq_pend));
      req_q  <= core_off && (pick != OWN_NONE) && (nst != ST_DMA);
      core_q <= !core_off && ((nst == ST_CORE) || (nst == ST_GPEND && !nrel));
    end
  end

endmodule

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl
  import bus_arb_pkg::*;
#(
  parameter int N_SDMA      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = (N_SDMA > 1) ? $clog2(N_SDMA) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_off,
  input  logic              irq_clr_en,
  input  logic              ext_req_n,
  input  logic              ext_gnt_n_in,
  input  logic              ack_n_in,
  input  logic [N_SDMA-1:0] sdma_req,
  input  logic              idma_req,
  input  logic              irq_pend,
  input  logic              cyc_done,
  output logic              gnt_n,
  output logic              gnt_oe,
  output logic              ack_drv_n,
  output logic              bclr_drv_n,
  output logic              req_drv_n,
  output logic              core_bus_en,
  output logic [1:0]        dma_own,
  output logic [CH_W-1:0]   sdma_ch
);

  logic [2:0]      pad_raw, pad_s;
  dma_own_t        pick, own_q;
  logic [CH_W-1:0] pick_ch;
  logic            sdma_any;
  logic            gnt_q, oe_q, ack_q, bclr_q, req_q, core_q;

  assign pad_raw = {~ext_gnt_n_in, ~ack_n_in, ~ext_req_n};

  bus_arb_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_raw),
    .q   (pad_s)
  );

  bus_arb_pick #(.N_SDMA(N_SDMA), .CH_W(CH_W)) u_pick (
    .sdma_req (sdma_req),
    .idma_req (idma_req),
    .pick     (pick),
    .pick_ch  (pick_ch),
    .sdma_any (sdma_any)
  );

  bus_arb_fsm #(.CH_W(CH_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .core_off   (core_off),
    .irq_clr_en (irq_clr_en),
    .irq_pend   (irq_pend),
    .cyc_done   (cyc_done),
    .ext_req_s  (pad_s[0]),
    .ack_s      (pad_s[1]),
    .ext_gnt_s  (pad_s[2]),
    .pick       (pick),
    .pick_ch    (pick_ch),
    .sdma_any   (sdma_any),
    .gnt_q      (gnt_q),
    .oe_q       (oe_q),
    .ack_q      (ack_q),
    .bclr_q     (bclr_q),
    .req_q      (req_q),
    .core_q     (core_q),
    .own_q      (own_q),
    .ch_q       (sdma_ch)
  );

  // Reset passes the request straight to the grant pad.
  assign gnt_n       = rst ? ext_req_n : ~gnt_q;
  assign gnt_oe      = oe_q;
  assign ack_drv_n   = ~ack_q;
  assign bclr_drv_n  = ~bclr_q;
  assign req_drv_n   = ~req_q;
  assign core_bus_en = core_q;
  assign dma_own     = own_q;

endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
  parameter int N_SDMA = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              core_off,
  input logic              cyc_done,
  input logic [N_SDMA-1:0] sdma_req,
  input logic              gnt_n,
  input logic              ack_drv_n,
  input logic              bclr_drv_n,
  input logic              core_bus_en,
  input logic [1:0]        dma_own
);

  AST_NO_GNT_CORE_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(core_off) |-> gnt_n);  // R10

  AST_ACK_TRACKS_OWNER: assert property (@(posedge clk) disable iff (rst)
    (ack_drv_n == 1'b0) == (dma_own != 2'd0));  // R8

  AST_STEAL_GAPLESS: assert property (@(posedge clk) disable iff (rst)
    ($past(dma_own) == 2'd2 && $past(|sdma_req) && $past(cyc_done)) |-> (dma_own == 2'd1 && !ack_drv_n));  // R9

  AST_CORE_LEAVES_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(core_bus_en) |-> ($past(cyc_done) || $past(core_off)));  // R2

  AST_BCLR_EXT_ONLY: assert property (@(posedge clk) disable iff (rst)
    !bclr_drv_n |-> (!core_bus_en && ack_drv_n && gnt_n));  // R6

  AST_GNT_ACK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!gnt_n && !ack_drv_n));  // R4

endmodule

bind bus_arb_ctrl bus_arb_chk #(.N_SDMA(N_SDMA)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .core_off    (core_off),
  .cyc_done    (cyc_done),
  .sdma_req    (sdma_req),
  .gnt_n       (gnt_n),
  .ack_drv_n   (ack_drv_n),
  .bclr_drv_n  (bclr_drv_n),
  .core_bus_en (core_bus_en),
  .dma_own     (dma_own)
);

// File: tb/tb_bus_arb_ctrl.sv
module tb_bus_arb_ctrl;

  localparam int N_SDMA = 3;
  localparam int CH_W   = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              core_off = 1'b0, irq_clr_en = 1'b0;
  logic              ext_req_n = 1'b1, ext_gnt_n_in = 1'b1, ack_n_in = 1'b1;
  logic [N_SDMA-1:0] sdma_req = '0;
  logic              idma_req = 1'b0, irq_pend = 1'b0, cyc_done = 1'b0;
  logic              gnt_n, gnt_oe, ack_drv_n, bclr_drv_n, req_drv_n, core_bus_en;
  logic [1:0]        dma_own;
  logic [CH_W-1:0]   sdma_ch;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  // expected output model
  logic       eg = 1, eoe = 1, ea = 1, eb = 1, er = 1, ec = 1;
  logic [1:0] eo = 0;
  logic [1:0] ech = 0;

  logic [9:0] q_v[$];
  string      q_t[$];

  always #5 clk = ~clk;

  bus_arb_ctrl #(.N_SDMA(N_SDMA)) dut (
    .clk(clk), .rst(rst), .core_off(core_off), .irq_clr_en(irq_clr_en),
    .ext_req_n(ext_req_n), .ext_gnt_n_in(ext_gnt_n_in), .ack_n_in(ack_n_in),
    .sdma_req(sdma_req), .idma_req(idma_req), .irq_pend(irq_pend),
    .cyc_done(cyc_done), .gnt_n(gnt_n), .gnt_oe(gnt_oe), .ack_drv_n(ack_drv_n),
    .bclr_drv_n(bclr_drv_n), .req_drv_n(req_drv_n), .core_bus_en(core_bus_en),
    .dma_own(dma_own), .sdma_ch(sdma_ch)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    cyc_done = 1'b1;
    @(negedge clk);
    cyc_done = 1'b0;
  endtask

  // driver side: push the expected output snapshot
  task automatic expect_out(input string tag);
    q_v.push_back({eg, eoe, ea, eb, er, ec, eo, ech});
    q_t.push_back(tag);
  endtask

  // monitor: pop and compare just after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q_v.size() > 0) begin
        logic [9:0] ev, av;
        string      t;
        ev = q_v.pop_front();
        t  = q_t.pop_front();
        av = {gnt_n, gnt_oe, ack_drv_n, bclr_drv_n, req_drv_n, core_bus_en, dma_own, sdma_ch};
        checks++;
        if (av !== ev) begin
          errors++;
          $display("FAIL %s actual=%b expected=%b", t, av, ev);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: pass-through during reset
    ext_req_n = 1'b0;
    step(4);
    eg = 0; expect_out("R1 reset passthrough low");
    step(1);
    ext_req_n = 1'b1;
    eg = 1; expect_out("R1 reset passthrough high");
    step(1);
    rst = 1'b0;
    step(1);
    expect_out("R1 idle after reset");

    // R2/R3: request, cycle complete, acknowledge
    ext_req_n = 1'b0;
    step(3);
    eg = 0; expect_out("R2 grant while core still owns");
    step(1);
    pulse_done();
    ec = 0; expect_out("R2 core releases on cycle complete");
    ack_n_in = 1'b0;
    step(3);
    eg = 1; expect_out("R3 grant drops after acknowledge");

    // R6/R7: bus clear during external ownership
    sdma_req = 3'b100;
    step(1);
    eb = 0; expect_out("R6 bus clear on serial request");
    sdma_req = '0;
    step(1);
    eb = 1; expect_out("R6 bus clear released");
    irq_pend = 1'b1;
    step(1);
    expect_out("R7 interrupt ignored when disabled");
    irq_clr_en = 1'b1;
    step(1);
    eb = 0; expect_out("R7 interrupt raises bus clear");
    irq_pend = 1'b0;
    step(1);
    eb = 1; expect_out("R7 bus clear drops");

    // R5: ack released while request still pending -> re-grant
    ack_n_in = 1'b1;
    step(3);
    eg = 0; expect_out("R5 re-grant, core stays off bus");
    ack_n_in = 1'b0;
    step(3);
    eg = 1; expect_out("R3 second acknowledge");
    ext_req_n = 1'b1;
    step(3);
    expect_out("R5 still external while ack held");
    ack_n_in = 1'b1;
    step(3);
    ec = 1; expect_out("R5 bus returns to core");

    // R4: acknowledge held by a previous master blocks grant
    ack_n_in = 1'b0;
    step(3);
    ext_req_n = 1'b0;
    step(3);
    expect_out("R4 no grant while ack low");
    ack_n_in = 1'b1;
    step(3);
    eg = 0; expect_out("R4 grant after ack release");
    ext_req_n = 1'b1;
    step(3);
    eg = 1; expect_out("R2 withdrawn request keeps core");

    // R8/R9/R11: internal DMA
    idma_req = 1'b1;
    step(2);
    expect_out("R8 no takeover without cycle complete");
    pulse_done();
    ea = 0; ec = 0; eo = 2; expect_out("R8 independent DMA owns");
    sdma_req = 3'b110;
    step(2);
    expect_out("R9 no steal before cycle complete");
    pulse_done();
    eo = 1; ech = 1; expect_out("R9 serial steals, lowest channel");
    sdma_req = '0;
    pulse_done();
    eo = 2; ech = 0; expect_out("R9 back to independent");
    idma_req = 1'b0;
    step(1);
    expect_out("R11 hold until cycle complete");
    pulse_done();
    ea = 1; ec = 1; eo = 0; expect_out("R11 bus back to core");

    // R10: core disabled
    core_off = 1'b1;
    step(1);
    eoe = 0; ec = 0; expect_out("R10 grant not driven");
    ext_req_n = 1'b0;
    step(3);
    expect_out("R10 external request ignored");
    ext_req_n = 1'b1;
    idma_req = 1'b1;
    step(1);
    er = 0; expect_out("R10 request driven for DMA");
    ext_gnt_n_in = 1'b0;
    step(3);
    ea = 0; er = 1; eo = 2; expect_out("R10 DMA takes bus on grant input");
    idma_req = 1'b0;
    pulse_done();
    ea = 1; eo = 0; expect_out("R11 DMA releases with core off");
    ext_gnt_n_in = 1'b1;
    core_off = 1'b0;
    step(1);
    eoe = 1; ec = 1; expect_out("R10 core re-enabled");

    step(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule